// File: doc/BRIEF.md
# Write-Through Cache with Store Queue

This block is a direct-mapped cache with one 32-bit word per line, placed between a processor and a slower memory. Every store goes to memory through a small first-in first-out queue of address/data pairs. A store that finds its word already cached also updates the cached copy. A store that misses leaves the cache untouched. The processor counts a store as finished once the queue has taken it, so it stalls only when every queue slot is occupied. Memory empties the queue in the background while the processor keeps issuing requests.

Reads that hit return the cached word one cycle after they are accepted. A read that misses the cache but matches a queued store is answered from the newest matching queue entry, without a memory access. Any other read miss first waits for the queue to empty. It then fetches the word from memory and fills the line, and the request is served as a hit.

The processor holds a request (valid, write flag, address, data) stable until ready is high. The memory side raises a request and holds it stable until a single-cycle acknowledge. On a read, the returned data is valid in the acknowledge cycle. Queued writes and line refills share this one memory port.

Top module: `wtc_cache`

## Requirements
- R1: After reset every line is invalid, the queue is empty, `cpu_rvalid` is 0 and `mem_req` is 0. The first read of any address therefore goes to memory.
- R2: The address splits into a byte offset of log2(LINE_BYTES) low bits, which is ignored, a set index of log2(SETS) bits above it, and a tag made of the remaining upper bits. Addresses that differ only in the offset reach the same word, and `mem_addr` always carries zero offset bits.
- R3: When the queue has a free slot, a store is accepted (`cpu_ready` = 1) in the first cycle it is presented, whatever the memory is doing.
- R4: While the queue is full, a store is held off (`cpu_ready` = 0) until memory acknowledges the oldest queued write.
- R5: A store whose word is cached updates the cached word, and a later read returns the new value without a memory read. A store that misses does not allocate: the line keeps its previous contents.
- R6: Queued writes appear on the memory port with `mem_we` = 1, one per request, in the order the stores were accepted. Memory ends up holding each stored value.
- R7: A read hit is accepted in the cycle it is presented, and `cpu_rvalid` = 1 with the word on `cpu_rdata` in the next cycle, without any memory read.
- R8: A read that misses the cache but matches one or more queued stores is accepted at once and returns the data of the most recent of those stores, without a memory read.
- R9: Any other read miss issues no memory read (`mem_we` = 0) until every queued write has been acknowledged. It then refills the line from memory and returns the fetched word.
- R10: Once `mem_req` is raised, it, `mem_we`, `mem_addr` and `mem_wdata` stay unchanged until the cycle in which `mem_ack` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_ready | output | 1 | Request accepted this cycle |
| cpu_we | input | 1 | 1 = store, 0 = read |
| cpu_addr | input | ADDR_W | Byte address of the request |
| cpu_wdata | input | DATA_W | Store data |
| cpu_rvalid | output | 1 | Read data valid, one cycle after an accepted read |
| cpu_rdata | output | DATA_W | Read data |
| mem_req | output | 1 | Memory request pending |
| mem_we | output | 1 | 1 = queued write, 0 = line refill |
| mem_addr | output | ADDR_W | Word-aligned memory address |
| mem_wdata | output | DATA_W | Write data to memory |
| mem_ack | input | 1 | Single-cycle completion of the pending request |
| mem_rdata | input | DATA_W | Refill data, valid with `mem_ack` |

## Verification
The bench builds the block with 16 sets and a four-entry queue. Two addresses 64 bytes apart then alias to the same line, which exercises no-allocate stores and line replacement with few addresses. A queue of four can be filled by four back-to-back stores while a slow memory (up to 40 cycles per access) holds its first write, which reaches the full-queue stall. The same slow memory keeps stores queued long enough to test forwarding to reads and to test that a refill waits for the queue to empty.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
   typedef enum logic [1:0] {
      MP_IDLE  = 2'd0,
      MP_WRITE = 2'd1,
      MP_READ  = 2'd2
   } mp_state_t;
endpackage

// File: rtl/wtc_wbuf.sv
module wtc_wbuf #(
   parameter int AW    = 30,
   parameter int DW    = 32,
   parameter int DEPTH = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [AW-1:0] push_addr,
   input  logic [DW-1:0] push_data,
   input  logic          pop,
   output logic [AW-1:0] head_addr,
   output logic [DW-1:0] head_data,
   output logic          empty,
   output logic          full,
   input  logic [AW-1:0] look_addr,
   output logic          look_hit,
   output logic [DW-1:0] look_data
);
   localparam int PW = $clog2(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("wtc_wbuf: DEPTH must be a power of two of at least 2");
   end

   logic [AW-1:0] addr_q [DEPTH];
   logic [DW-1:0] data_q [DEPTH];
   logic [PW-1:0] rd_ptr, wr_ptr;
   logic [PW:0]   cnt;

   assign empty     = (cnt == '0);
   assign full      = (cnt == (PW+1)'(DEPTH));
   assign head_addr = addr_q[rd_ptr];
   assign head_data = data_q[rd_ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + 1'b1;
         if (pop)  rd_ptr <= rd_ptr + 1'b1;
         cnt <= cnt + (PW+1)'(push) - (PW+1)'(pop);
      end
   end

   always_ff @(posedge clk) begin
      if (push) begin
         addr_q[wr_ptr] <= push_addr;
         data_q[wr_ptr] <= push_data;
      end
   end

   // per-slot age (distance from the oldest entry) and match
   logic [PW-1:0]    ent_age   [DEPTH];
   logic [DEPTH-1:0] ent_match;

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      assign ent_age[i]   = PW'(i) - rd_ptr;
      assign ent_match[i] = ({1'b0, ent_age[i]} < cnt) && (addr_q[i] == look_addr);
   end

   // newest matching entry wins
   always_comb begin
      logic [PW-1:0] best;
      look_hit  = 1'b0;
      look_data = '0;
      best      = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (ent_match[i] && (!look_hit || ent_age[i] > best)) begin
            look_hit  = 1'b1;
            look_data = data_q[i];
            best      = ent_age[i];
         end
      end
   end

   // R4: the queue is never pushed while full
   p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   // R6: a drain never pops an empty queue
   p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
endmodule

// File: rtl/wtc_lines.sv
module wtc_lines #(
   parameter int SETS  = 1024,
   parameter int TAG_W = 20,
   parameter int DW    = 32,
   localparam int IDX_W = $clog2(SETS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   input  logic [TAG_W-1:0] rd_tag,
   output logic             hit,
   output logic [DW-1:0]    rd_data,
   input  logic             upd_en,
   input  logic             upd_fill,
   input  logic [IDX_W-1:0] upd_idx,
   input  logic [TAG_W-1:0] upd_tag,
   input  logic [DW-1:0]    upd_data
);
   if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
      $error("wtc_lines: SETS must be a power of two of at least 2");
   end

   logic [SETS-1:0]  valid_q;
   logic [TAG_W-1:0] tag_q  [SETS];
   logic [DW-1:0]    data_q [SETS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         valid_q <= '0;
      else if (upd_en && upd_fill)
         valid_q[upd_idx] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (upd_en) begin
         data_q[upd_idx] <= upd_data;
         if (upd_fill) tag_q[upd_idx] <= upd_tag;
      end
   end

   assign hit     = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
   assign rd_data = data_q[rd_idx];

   // R5: a data-only update targets a line that is already valid
   p_update_valid_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && !upd_fill) |-> valid_q[upd_idx]);
endmodule

// File: rtl/wtc_memport.sv
module wtc_memport #(
   parameter int AW = 30,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wb_empty,
   input  logic [AW-1:0] wb_addr,
   input  logic [DW-1:0] wb_data,
   output logic          wb_pop,
   input  logic          rd_want,
   input  logic [AW-1:0] rd_addr,
   output logic          fill_en,
   output logic [DW-1:0] fill_data,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic          mem_ack,
   input  logic [DW-1:0] mem_rdata
);
   import wtc_pkg::*;

   mp_state_t     state_q;
   logic [AW-1:0] addr_q;
   logic [DW-1:0] data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= MP_IDLE;
         addr_q  <= '0;
         data_q  <= '0;
      end else begin
         unique case (state_q)
            MP_IDLE: begin
               if (!wb_empty) begin
                  state_q <= MP_WRITE;
                  addr_q  <= wb_addr;
                  data_q  <= wb_data;
               end else if (rd_want) begin
                  state_q <= MP_READ;
                  addr_q  <= rd_addr;
               end
            end
            MP_WRITE, MP_READ: if (mem_ack) state_q <= MP_IDLE;
            default: state_q <= MP_IDLE;
         endcase
      end
   end

   assign mem_req   = (state_q != MP_IDLE);
   assign mem_we    = (state_q == MP_WRITE);
   assign mem_addr  = addr_q;
   assign mem_wdata = data_q;
   assign wb_pop    = (state_q == MP_WRITE) && mem_ack;
   assign fill_en   = (state_q == MP_READ) && mem_ack;
   assign fill_data = mem_rdata;

   // R10: request fields hold until acknowledged
   p_req_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) &&
                                 $stable(mem_addr) && $stable(mem_wdata)));
   // R9: a refill never runs while writes remain queued
   p_read_after_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we) |-> wb_empty);
endmodule

// File: rtl/wtc_cache.sv
module wtc_cache #(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int SETS       = 1024,
   parameter int LINE_BYTES = 4,
   parameter int WBUF_DEPTH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_valid,
   output logic              cpu_ready,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic              cpu_rvalid,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata
);
   localparam int OFF_W = $clog2(LINE_BYTES);
   localparam int IDX_W = $clog2(SETS);
   localparam int WA_W  = ADDR_W - OFF_W;
   localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

   if (LINE_BYTES * 8 != DATA_W || OFF_W < 1) begin : g_bad_line
      $error("wtc_cache: a line must hold exactly one data word of two or more bytes");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("wtc_cache: address too narrow for the chosen set count");
   end

   // address split (R2)
   logic [WA_W-1:0]  cpu_word;
   logic [IDX_W-1:0] cpu_idx;
   logic [TAG_W-1:0] cpu_tag;
   logic             unused_offset;
   assign cpu_word      = cpu_addr[ADDR_W-1:OFF_W];
   assign cpu_idx       = cpu_word[IDX_W-1:0];
   assign cpu_tag       = cpu_word[WA_W-1 -: TAG_W];
   assign unused_offset = ^cpu_addr[OFF_W-1:0];

   logic              line_hit;
   logic [DATA_W-1:0] line_data;
   logic              wb_empty, wb_full, wb_pop, wb_look_hit;
   logic [WA_W-1:0]   wb_head_addr;
   logic [DATA_W-1:0] wb_head_data, wb_look_data;
   logic              fill_en;
   logic [DATA_W-1:0] fill_data;
   logic [WA_W-1:0]   mem_word;

   logic is_rd, is_wr, wr_go, rd_go, rd_want;
   assign is_rd   = cpu_valid && !cpu_we;
   assign is_wr   = cpu_valid && cpu_we;
   assign wr_go   = is_wr && !wb_full;
   assign rd_go   = is_rd && (line_hit || wb_look_hit);
   assign rd_want = is_rd && !line_hit && !wb_look_hit;
   assign cpu_ready = wr_go || rd_go;

   // a refill has priority; a store hit rewrites only the data word
   logic             upd_en;
   logic [IDX_W-1:0] upd_idx;
   logic [TAG_W-1:0] upd_tag;
   logic [DATA_W-1:0] upd_data;
   assign upd_en   = fill_en || (wr_go && line_hit);
   assign upd_idx  = fill_en ? mem_word[IDX_W-1:0] : cpu_idx;
   assign upd_tag  = mem_word[WA_W-1 -: TAG_W];
   assign upd_data = fill_en ? fill_data : cpu_wdata;

   wtc_lines #(.SETS(SETS), .TAG_W(TAG_W), .DW(DATA_W)) u_lines (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (cpu_idx),
      .rd_tag   (cpu_tag),
      .hit      (line_hit),
      .rd_data  (line_data),
      .upd_en   (upd_en),
      .upd_fill (fill_en),
      .upd_idx  (upd_idx),
      .upd_tag  (upd_tag),
      .upd_data (upd_data)
   );

   wtc_wbuf #(.AW(WA_W), .DW(DATA_W), .DEPTH(WBUF_DEPTH)) u_wbuf (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (wr_go),
      .push_addr (cpu_word),
      .push_data (cpu_wdata),
      .pop       (wb_pop),
      .head_addr (wb_head_addr),
      .head_data (wb_head_data),
      .empty     (wb_empty),
      .full      (wb_full),
      .look_addr (cpu_word),
      .look_hit  (wb_look_hit),
      .look_data (wb_look_data)
   );

   wtc_memport #(.AW(WA_W), .DW(DATA_W)) u_memport (
      .clk       (clk),
      .rst_n     (rst_n),
      .wb_empty  (wb_empty),
      .wb_addr   (wb_head_addr),
      .wb_data   (wb_head_data),
      .wb_pop    (wb_pop),
      .rd_want   (rd_want),
      .rd_addr   (cpu_word),
      .fill_en   (fill_en),
      .fill_data (fill_data),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_word),
      .mem_wdata (mem_wdata),
      .mem_ack   (mem_ack),
      .mem_rdata (mem_rdata)
   );

   assign mem_addr = {mem_word, {OFF_W{1'b0}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cpu_rvalid <= 1'b0;
         cpu_rdata  <= '0;
      end else begin
         cpu_rvalid <= rd_go;
         if (rd_go) cpu_rdata <= line_hit ? line_data : wb_look_data;
      end
   end

   // R4: a full queue holds off stores
   p_full_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (is_wr && wb_full) |-> !cpu_ready);
   // R7: read data appears only after an accepted read
   p_rvalid_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rvalid |-> $past(cpu_valid && cpu_ready && !cpu_we));
   // R9: a read that still needs memory is never accepted early
   p_miss_waits_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (is_rd && !line_hit && !wb_look_hit) |-> !cpu_ready);
endmodule

// File: tb/tb_wtc_cache.sv
`timescale 1ns/1ps
module tb_wtc_cache;
   localparam int SETS  = 16;
   localparam int DEPTH = 4;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cpu_valid, cpu_we, cpu_ready, cpu_rvalid;
   logic [31:0] cpu_addr, cpu_wdata, cpu_rdata;
   logic        mem_req, mem_we, mem_ack;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;

   always #2 clk = ~clk;

   wtc_cache #(.ADDR_W(32), .DATA_W(32), .SETS(SETS), .LINE_BYTES(4),
               .WBUF_DEPTH(DEPTH)) dut (
      .clk(clk), .rst_n(rst_n),
      .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_we(cpu_we),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata));

   int n_chk = 0, n_fail = 0;
   int lat = 2;
   int st_acc = 0;
   int rd_n = 0;
   int wlog_n = 0;
   int unstable = 0, offs_bad = 0, rd_order_bad = 0;
   logic [31:0] last_rd_addr;
   logic [31:0] wlog_a [64];
   logic [31:0] wlog_d [64];
   logic [31:0] mem_m [logic [31:0]];

   function automatic logic [31:0] seed(input logic [31:0] wa);
      return {wa[15:0] ^ 16'h5a5a, ~wa[15:0]};
   endfunction

   function automatic logic [31:0] model_rd(input logic [31:0] wa);
      if (mem_m.exists(wa)) return mem_m[wa];
      return seed(wa);
   endfunction

   task automatic check(input bit ok, input string req,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // memory model: fixed latency, single-cycle ack
   initial begin
      int pend;
      logic [31:0] ca, cd;
      logic cw;
      pend = 0; ca = '0; cd = '0; cw = 1'b0;
      mem_ack = 1'b0; mem_rdata = '0;
      forever begin
         @(negedge clk);
         if (mem_ack) begin
            mem_ack = 1'b0;
         end else if (rst_n && mem_req) begin
            if (pend == 0) begin
               ca = mem_addr; cd = mem_wdata; cw = mem_we;
               if (mem_addr[1:0] != 2'b00) offs_bad++;
            end else if (mem_addr != ca || mem_we != cw || (cw && mem_wdata != cd)) begin
               unstable++;
            end
            pend++;
            if (pend >= lat) begin
               mem_ack = 1'b1;
               pend = 0;
               if (cw) begin
                  mem_m[ca >> 2] = cd;
                  wlog_a[wlog_n % 64] = ca;
                  wlog_d[wlog_n % 64] = cd;
                  wlog_n++;
               end else begin
                  mem_rdata = model_rd(ca >> 2);
                  last_rd_addr = ca;
                  rd_n++;
                  if (wlog_n != st_acc) rd_order_bad++;
               end
            end
         end
      end
   end

   task automatic cpu_write(input logic [31:0] a, input logic [31:0] d, output int waits);
      cpu_valid = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
      waits = 0;
      #1;
      while (!cpu_ready) begin
         @(negedge clk); #1; waits++;
      end
      @(negedge clk);
      cpu_valid = 1'b0;
      st_acc++;
   endtask

   task automatic cpu_read(input logic [31:0] a, output logic [31:0] d,
                           output int waits, output logic rv);
      cpu_valid = 1'b1; cpu_we = 1'b0; cpu_addr = a; cpu_wdata = '0;
      waits = 0;
      #1;
      while (!cpu_ready) begin
         @(negedge clk); #1; waits++;
      end
      @(negedge clk);
      cpu_valid = 1'b0;
      rv = cpu_rvalid;
      d  = cpu_rdata;
   endtask

   task automatic wait_drain();
      while (wlog_n != st_acc || mem_req) @(negedge clk);
   endtask

   localparam logic [31:0] A = 32'h0000_1040;
   localparam logic [31:0] B = A + 32'd64;

   task automatic t_reset();
      check(cpu_rvalid == 1'b0, "R1 rvalid after reset", 32'(cpu_rvalid), 32'd0);
      check(mem_req == 1'b0, "R1 mem_req after reset", 32'(mem_req), 32'd0);
   endtask

   task automatic t_cold_miss();
      logic [31:0] d; int w; logic rv; int r0;
      r0 = rd_n;
      cpu_read(A, d, w, rv);
      check(rv && d == seed(A >> 2), "R9 R1 cold read data", d, seed(A >> 2));
      check(rd_n == r0 + 1, "R1 cold read goes to memory", 32'(rd_n - r0), 32'd1);
      check(last_rd_addr == A, "R2 refill address", last_rd_addr, A);
   endtask

   task automatic t_hit();
      logic [31:0] d; int w; logic rv; int r0;
      r0 = rd_n;
      cpu_read(A, d, w, rv);
      check(rv && d == seed(A >> 2) && w == 0, "R7 read hit", d, seed(A >> 2));
      check(rd_n == r0, "R7 hit makes no memory read", 32'(rd_n - r0), 32'd0);
      cpu_read(A + 32'd1, d, w, rv);
      check(rv && d == seed(A >> 2) && w == 0, "R2 offset ignored on read", d, seed(A >> 2));
   endtask

   task automatic t_store_hit();
      logic [31:0] d; int w; logic rv; int r0;
      cpu_write(A, 32'h1111_2222, w);
      check(w == 0, "R3 store accepted at once", 32'(w), 32'd0);
      r0 = rd_n;
      cpu_read(A, d, w, rv);
      check(rv && d == 32'h1111_2222, "R5 store hit updates line", d, 32'h1111_2222);
      check(rd_n == r0, "R5 no memory read after store hit", 32'(rd_n - r0), 32'd0);
      wait_drain();
      check(model_rd(A >> 2) == 32'h1111_2222, "R6 store reaches memory",
            model_rd(A >> 2), 32'h1111_2222);
   endtask

   task automatic t_no_allocate();
      logic [31:0] d; int w; logic rv; int r0;
      cpu_write(B, 32'h3333_4444, w);
      r0 = rd_n;
      cpu_read(A, d, w, rv);
      check(rv && d == 32'h1111_2222 && rd_n == r0, "R5 store miss keeps line",
            d, 32'h1111_2222);
      wait_drain();
      cpu_read(B, d, w, rv);
      check(rv && d == 32'h3333_4444, "R9 refill after no-allocate store", d, 32'h3333_4444);
      check(rd_n == r0 + 1, "R5 store miss did not allocate", 32'(rd_n - r0), 32'd1);
   endtask

   task automatic t_forward();
      logic [31:0] d; int w; logic rv; int r0;
      lat = 30;
      cpu_write(32'h0000_2000, 32'h0000_0001, w);
      cpu_write(32'h0000_2000, 32'h0000_0002, w);
      cpu_write(32'h0000_2104, 32'h0000_0003, w);
      r0 = rd_n;
      cpu_read(32'h0000_2000, d, w, rv);
      check(rv && d == 32'h0000_0002 && w == 0, "R8 newest queued data forwarded",
            d, 32'h0000_0002);
      check(rd_n == r0, "R8 forward makes no memory read", 32'(rd_n - r0), 32'd0);
      wait_drain();
      lat = 2;
   endtask

   task automatic t_miss_waits();
      logic [31:0] d; int w; logic rv; int r0, l0;
      lat = 10;
      l0 = wlog_n;
      cpu_write(32'h0000_3000, 32'hE0E0_0001, w);
      cpu_write(32'h0000_3004, 32'hE0E0_0002, w);
      cpu_write(32'h0000_3008, 32'hE0E0_0003, w);
      r0 = rd_n;
      cpu_read(32'h0000_4010, d, w, rv);
      check(rv && d == seed(32'h0000_4010 >> 2), "R9 miss data after drain",
            d, seed(32'h0000_4010 >> 2));
      check(rd_order_bad == 0 && rd_n == r0 + 1, "R9 refill waited for queue",
            32'(rd_order_bad), 32'd0);
      for (int k = 0; k < 3; k++) begin
         check(wlog_a[(l0 + k) % 64] == 32'h0000_3000 + 32'(4 * k),
               "R6 write order", wlog_a[(l0 + k) % 64], 32'h0000_3000 + 32'(4 * k));
      end
      lat = 2;
   endtask

   task automatic t_full_stall();
      int w; int l0;
      lat = 40;
      l0 = wlog_n;
      for (int k = 0; k < DEPTH + 1; k++) begin
         cpu_write(32'h0000_5000 + 32'(4 * k), 32'hF000_0000 + 32'(k), w);
         if (k < DEPTH)
            check(w == 0, "R3 store with free slot", 32'(w), 32'd0);
         else
            check(w > 0, "R4 store stalls on full queue", 32'(w), 32'd1);
      end
      wait_drain();
      for (int k = 0; k < DEPTH + 1; k++) begin
         check(wlog_a[(l0 + k) % 64] == 32'h0000_5000 + 32'(4 * k) &&
               wlog_d[(l0 + k) % 64] == 32'hF000_0000 + 32'(k),
               "R6 drain order and data", wlog_d[(l0 + k) % 64], 32'hF000_0000 + 32'(k));
      end
      lat = 2;
   endtask

   task automatic t_offset_store();
      int w;
      cpu_write(32'h0000_6003, 32'h0BAD_F00D, w);
      wait_drain();
      check(wlog_a[(wlog_n - 1) % 64] == 32'h0000_6000, "R2 store address aligned",
            wlog_a[(wlog_n - 1) % 64], 32'h0000_6000);
      check(offs_bad == 0, "R2 no offset bits on memory port", 32'(offs_bad), 32'd0);
      check(unstable == 0, "R10 request held until ack", 32'(unstable), 32'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      cpu_valid = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_cold_miss();
      t_hit();
      t_store_hit();
      t_no_allocate();
      t_forward();
      t_miss_waits();
      t_full_stall();
      t_offset_store();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule